// File: doc/BRIEF.md
# Sector Write and Format Intake Sequencer

This block runs the host-to-disk half of a floppy disk controller's data commands: writing a sector, writing a sector that carries a deleted-data mark, and formatting a track. When a command starts, it first checks the drive's write-protect line. It then offers a data request to the host and holds one host byte at a time. It passes each held byte to the disk serializer when the serializer asks for the next one. The serializer itself, along with address marks, CRC and gaps, lives outside this block.

The host has to keep pace with the medium. If the serializer asks for a byte before the host has written one, the command ends with an overrun. During a format, the host supplies four ID bytes for every sector. An index pulse that arrives while the format is still collecting ID bytes also ends the command with an overrun. Every command, whether it finishes or is cut short, closes with a seven-byte result phase that the host reads back: ST0, ST1, ST2, then the cylinder, head, record and size-code values the command was given.

Top module: `wfi_intake`

## Requirements
- R1: Out of reset, `rqm`, `dio`, `ser_gate`, `ser_deleted`, `ser_load` and `busy` are all low.
- R2: The command code on `cmd_op` is 0 for write data, 1 for write deleted data and 2 for format track. A `cmd_start` with code 3 is ignored. A `cmd_start` that arrives while `busy` is high is ignored.
- R3: If `wr_prot` is high when a valid command starts, `ser_gate` never rises and the result phase follows on the next cycle. In that result, ST0 = 0x40 | head<<2 | unit and ST1 = 0x02.
- R4: If the drive is not write-protected, then on the cycle after a valid start `ser_gate` and `rqm` are high and `dio` is low, meaning data flows from the host to the block.
- R5: A `host_wr` while `rqm` is high and `dio` is low captures `host_din` and drops `rqm` on the next cycle. A `host_wr` while `rqm` is low has no effect.
- R6: A `ser_need` while a byte is held pulses `ser_load` high for exactly one cycle, with that byte on `ser_byte`. Bytes reach the serializer in the order the host wrote them, and `rqm` rises again unless the byte was the last one.
- R7: A `ser_need` while no byte is held aborts the command: `ser_gate` drops, and the result carries ST0 = 0x40 | head<<2 | unit and ST1 = 0x10.
- R8: A write command moves exactly 128 << N bytes, where N is `cmd_size`.
- R9: A format command moves exactly 4 × `fmt_sectors` bytes. A value of 0 in `fmt_sectors` stands for 256 sectors.
- R10: An `index_pulse` during a format transfer aborts the command with ST1 = 0x10. The abort happens even if a host byte is being held.
- R11: `ser_deleted` is high for the whole of a write-deleted transfer and low for the other commands.
- R12: On the cycle after the last byte is handed over, or after an abort, `ser_gate` is low while `rqm` and `dio` are both high. The host then reads ST0, ST1, ST2, C, H, R, N from `host_dout`, one byte per `host_rd`. On normal completion ST0 = head<<2 | unit and ST1 = ST2 = 0. After the seventh read, `busy`, `rqm` and `dio` fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | One-cycle command start pulse |
| cmd_op | input | 2 | Command code (see R2) |
| cmd_unit | input | 2 | Drive unit number |
| cmd_head | input | 1 | Head select |
| cmd_cyl | input | 8 | Cylinder value echoed in the result |
| cmd_rec | input | 8 | Record value echoed in the result |
| cmd_size | input | 3 | Size code N |
| fmt_sectors | input | 8 | Sectors per track for a format (0 means 256) |
| wr_prot | input | 1 | Drive write-protect line |
| host_wr | input | 1 | Host write strobe |
| host_din | input | 8 | Host write data |
| host_rd | input | 1 | Host result-read strobe |
| host_dout | output | 8 | Current result byte |
| rqm | output | 1 | Data request to the host |
| dio | output | 1 | Direction: 1 means block to host |
| busy | output | 1 | Command in progress |
| ser_need | input | 1 | Serializer asks for its next byte |
| index_pulse | input | 1 | Index hole pulse |
| ser_load | output | 1 | Byte handed to the serializer |
| ser_byte | output | 8 | Byte for the serializer |
| ser_gate | output | 1 | Write gate |
| ser_deleted | output | 1 | Select the deleted-data mark |

## Verification
The bench looks for the race between the host and the serializer.

- **Late host byte:** a `ser_need` that arrives one byte before the host's next write must raise overrun. A design that stalled instead would report clean completion with a short sector.
- **Repeated host write:** a second `host_wr` while `rqm` is low is sent in. A design that accepted it would overwrite the held byte, and the scoreboard would see the wrong byte reach the serializer.
- **Index pulse over a held byte:** an index pulse is sent during a format while a byte is still held. A design that let the held byte win would carry on formatting.
- **Transfer length:** the bench counts the exact number of hand-overs for both size rules, so an off-by-one in the length shows up as a count mismatch.
- **Write-protect:** the bench checks that the write gate never rises on a protected drive.

// File: rtl/wfi_pkg.sv
// Package: shared codes and status constants for the write/format intake.
// Assumes 8-bit status bytes; codes are fixed by the command interface.
package wfi_pkg;
    typedef enum logic [1:0] {
        OP_WRITE     = 2'd0,
        OP_WRITE_DEL = 2'd1,
        OP_FORMAT    = 2'd2,
        OP_NONE      = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_XFER   = 2'd1,
        PH_RESULT = 2'd2
    } phase_e;

    localparam int unsigned RES_BYTES     = 7;
    localparam logic [7:0]  ST1_NO_WRITE  = 8'h02;
    localparam logic [7:0]  ST1_OVERRUN   = 8'h10;
    localparam logic [1:0]  ST0_CODE_OK   = 2'b00;
    localparam logic [1:0]  ST0_CODE_ABN  = 2'b01;
endpackage

// File: rtl/wfi_byte_latch.sv
// Module: single-byte holding register between host and serializer.
// Assumes load and take never coincide (load only while nothing is held).
module wfi_byte_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              take,
    output logic [DATA_W-1:0] dout,
    output logic              held
);
    // Capture a host byte, release it when the serializer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            held <= 1'b0;
        end else if (clear || take) begin
            held <= 1'b0;
        end else if (load) begin
            dout <= din;
            held <= 1'b1;
        end
    end
endmodule

// File: rtl/wfi_xfer_count.sv
// Module: transfer length counter; computes the byte total at arm time
// (128<<N for writes, 4 per sector for format, 0 sectors meaning the maximum).
// Assumes CNT_W is wide enough for both totals.
module wfi_xfer_count #(
    parameter int SIZE_W = 3,
    parameter int SECT_W = 8,
    parameter int CNT_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              is_format,
    input  logic [SIZE_W-1:0] size_code,
    input  logic [SECT_W-1:0] sectors,
    input  logic              step,
    output logic              last
);
    logic [CNT_W-1:0] total_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] total_d;
    logic [SECT_W:0]  sect_ext;

    // Derive the byte total for the command being armed.
    always_comb begin
        sect_ext = {(sectors == '0), sectors};
        if (is_format) total_d = CNT_W'(sect_ext) << 2;
        else           total_d = CNT_W'(128) << size_code;
    end

    // Hold the total and count bytes handed to the serializer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_q <= '0;
            count_q <= '0;
        end else if (arm) begin
            total_q <= total_d;
            count_q <= '0;
        end else if (step) begin
            count_q <= count_q + 1'b1;
        end
    end

    // The current hand-over is the final one.
    assign last = step && (count_q == total_q - 1'b1);
endmodule

// File: rtl/wfi_result_seq.sv
// Module: result phase sequencer presenting ST0, ST1, ST2, C, H, R, N.
// Assumes rd is only asserted while active.
module wfi_result_seq #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [DATA_W-1:0] st0,
    input  logic [DATA_W-1:0] st1,
    input  logic [DATA_W-1:0] cyl,
    input  logic [DATA_W-1:0] head,
    input  logic [DATA_W-1:0] rec,
    input  logic [DATA_W-1:0] size,
    input  logic              active,
    input  logic              rd,
    output logic [DATA_W-1:0] dout,
    output logic              done
);
    import wfi_pkg::*;
    localparam int IDX_W = $clog2(RES_BYTES);

    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] bytes_q [RES_BYTES];

    // Capture the result bytes on arm and step through them on reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            for (int i = 0; i < RES_BYTES; i++) bytes_q[i] <= '0;
        end else if (arm) begin
            idx_q      <= '0;
            bytes_q[0] <= st0;
            bytes_q[1] <= st1;
            bytes_q[2] <= '0;
            bytes_q[3] <= cyl;
            bytes_q[4] <= head;
            bytes_q[5] <= rec;
            bytes_q[6] <= size;
        end else if (active && rd) begin
            idx_q <= (idx_q == IDX_W'(RES_BYTES - 1)) ? '0 : idx_q + 1'b1;
        end
    end

    // Present the current byte and flag the final read.
    assign dout = active ? bytes_q[idx_q] : '0;
    assign done = active && rd && (idx_q == IDX_W'(RES_BYTES - 1));
endmodule

// File: rtl/wfi_intake.sv
// Module: write/format intake sequencer. Checks write protection, runs the
// host data request handshake, feeds the serializer on demand, detects
// overrun and format index aborts, then runs the seven-byte result phase.
// Assumes ser_need and index_pulse are single-cycle pulses from the drive side.
module wfi_intake #(
    parameter int DATA_W = 8,
    parameter int SIZE_W = 3,
    parameter int SECT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_op,
    input  logic [1:0]        cmd_unit,
    input  logic              cmd_head,
    input  logic [DATA_W-1:0] cmd_cyl,
    input  logic [DATA_W-1:0] cmd_rec,
    input  logic [SIZE_W-1:0] cmd_size,
    input  logic [SECT_W-1:0] fmt_sectors,
    input  logic              wr_prot,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_din,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_dout,
    output logic              rqm,
    output logic              dio,
    output logic              busy,
    input  logic              ser_need,
    input  logic              index_pulse,
    output logic              ser_load,
    output logic [DATA_W-1:0] ser_byte,
    output logic              ser_gate,
    output logic              ser_deleted
);
    import wfi_pkg::*;

    localparam int WR_CNT_W  = (1 << SIZE_W) + 7;
    localparam int FMT_CNT_W = SECT_W + 3;
    localparam int CNT_W     = (WR_CNT_W > FMT_CNT_W) ? WR_CNT_W : FMT_CNT_W;

    phase_e            phase_q;
    op_e               op_q;
    logic              rqm_q, dio_q, gate_q, del_q, load_q;
    logic [DATA_W-1:0] byte_q;
    logic [2:0]        hu_q;
    logic [DATA_W-1:0] cyl_q, rec_q;
    logic [SIZE_W-1:0] size_q;

    logic              valid_start, accept, need, idx_abort, take, overrun;
    logic              finish, last, held, res_done, res_arm, prot_stop;
    logic [DATA_W-1:0] held_byte;
    logic [2:0]        hu_now;
    logic [DATA_W-1:0] st0_d, st1_d, cyl_now, rec_now, head_now, size_now;

    // Decode the events of this cycle.
    always_comb begin
        valid_start = cmd_start && (phase_q == PH_IDLE) && (op_e'(cmd_op) != OP_NONE);
        prot_stop   = valid_start && wr_prot;
        accept      = (phase_q == PH_XFER) && rqm_q && !dio_q && host_wr;
        need        = (phase_q == PH_XFER) && ser_need;
        idx_abort   = (phase_q == PH_XFER) && (op_q == OP_FORMAT) && index_pulse;
        take        = need && held && !idx_abort;
        overrun     = idx_abort || (need && !held);
        finish      = take && last;
        res_arm     = prot_stop || (phase_q == PH_XFER && (overrun || finish));
    end

    // Pick command fields live at start, from the capture afterwards.
    always_comb begin
        hu_now   = (phase_q == PH_IDLE) ? {cmd_head, cmd_unit} : hu_q;
        cyl_now  = (phase_q == PH_IDLE) ? cmd_cyl : cyl_q;
        rec_now  = (phase_q == PH_IDLE) ? cmd_rec : rec_q;
        size_now = DATA_W'((phase_q == PH_IDLE) ? cmd_size : size_q);
        head_now = DATA_W'(hu_now[2]);
    end

    // Form ST0 and ST1 for the result being armed.
    always_comb begin
        if (prot_stop) begin
            st0_d = {ST0_CODE_ABN, 3'b000, hu_now};
            st1_d = ST1_NO_WRITE;
        end else if (overrun) begin
            st0_d = {ST0_CODE_ABN, 3'b000, hu_now};
            st1_d = ST1_OVERRUN;
        end else begin
            st0_d = {ST0_CODE_OK, 3'b000, hu_now};
            st1_d = '0;
        end
    end

    // Capture command fields when a command starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_NONE;
            hu_q   <= '0;
            cyl_q  <= '0;
            rec_q  <= '0;
            size_q <= '0;
        end else if (valid_start) begin
            op_q   <= op_e'(cmd_op);
            hu_q   <= {cmd_head, cmd_unit};
            cyl_q  <= cmd_cyl;
            rec_q  <= cmd_rec;
            size_q <= cmd_size;
        end
    end

    // Phase sequencing, handshake flags, write gate and serializer hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            rqm_q   <= 1'b0;
            dio_q   <= 1'b0;
            gate_q  <= 1'b0;
            del_q   <= 1'b0;
            load_q  <= 1'b0;
            byte_q  <= '0;
        end else begin
            load_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (prot_stop) begin
                        phase_q <= PH_RESULT;
                        rqm_q   <= 1'b1;
                        dio_q   <= 1'b1;
                    end else if (valid_start) begin
                        phase_q <= PH_XFER;
                        rqm_q   <= 1'b1;
                        dio_q   <= 1'b0;
                        gate_q  <= 1'b1;
                        del_q   <= (op_e'(cmd_op) == OP_WRITE_DEL);
                    end
                end
                PH_XFER: begin
                    if (overrun || finish) begin
                        phase_q <= PH_RESULT;
                        gate_q  <= 1'b0;
                        del_q   <= 1'b0;
                        rqm_q   <= 1'b1;
                        dio_q   <= 1'b1;
                    end else if (accept) begin
                        rqm_q <= 1'b0;
                    end else if (take) begin
                        rqm_q <= 1'b1;
                    end
                    if (take) begin
                        load_q <= 1'b1;
                        byte_q <= held_byte;
                    end
                end
                PH_RESULT: begin
                    if (res_done) begin
                        phase_q <= PH_IDLE;
                        rqm_q   <= 1'b0;
                        dio_q   <= 1'b0;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    wfi_byte_latch #(.DATA_W(DATA_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (phase_q != PH_XFER),
        .load  (accept),
        .din   (host_din),
        .take  (take),
        .dout  (held_byte),
        .held  (held)
    );

    wfi_xfer_count #(.SIZE_W(SIZE_W), .SECT_W(SECT_W), .CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (valid_start),
        .is_format (op_e'(cmd_op) == OP_FORMAT),
        .size_code (cmd_size),
        .sectors   (fmt_sectors),
        .step      (take),
        .last      (last)
    );

    wfi_result_seq #(.DATA_W(DATA_W)) u_result (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (res_arm),
        .st0    (st0_d),
        .st1    (st1_d),
        .cyl    (cyl_now),
        .head   (head_now),
        .rec    (rec_now),
        .size   (size_now),
        .active (phase_q == PH_RESULT),
        .rd     (host_rd),
        .dout   (host_dout),
        .done   (res_done)
    );

    assign rqm         = rqm_q;
    assign dio         = dio_q;
    assign busy        = (phase_q != PH_IDLE);
    assign ser_load    = load_q;
    assign ser_byte    = byte_q;
    assign ser_gate    = gate_q;
    assign ser_deleted = del_q;
endmodule

// File: rtl/wfi_intake_chk.sv
// Module: port-level temporal checks for wfi_intake, attached by bind.
// Assumes the default data width.
module wfi_intake_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_start,
    input logic [1:0] cmd_op,
    input logic       wr_prot,
    input logic       host_wr,
    input logic       ser_need,
    input logic       index_pulse,
    input logic       rqm,
    input logic       dio,
    input logic       busy,
    input logic       ser_load,
    input logic       ser_gate,
    input logic       ser_deleted
);
    // R6: a hand-over is a single-cycle pulse
    a_r6_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        ser_load |=> !ser_load);

    // R3: a protected start never opens the write gate
    a_r3_protect_no_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !busy && cmd_op != 2'd3 && wr_prot) |=> (!ser_gate && rqm && dio));

    // R5: an accepted host byte withdraws the data request
    a_r5_rqm_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rqm && !dio && host_wr && !ser_need && !index_pulse) |=> !rqm);

    // R12: gate release coincides with the start of the result phase
    a_r12_gate_to_result: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_gate) |-> (rqm && dio));

    // R4: while the gate is open, data flows from the host
    a_r4_gate_dir: assert property (@(posedge clk) disable iff (!rst_n)
        ser_gate |-> !dio);

    // R11: the deleted-mark select only appears during a transfer
    a_r11_del_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ser_deleted |-> ser_gate);
endmodule

bind wfi_intake wfi_intake_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start   (cmd_start),
    .cmd_op      (cmd_op),
    .wr_prot     (wr_prot),
    .host_wr     (host_wr),
    .ser_need    (ser_need),
    .index_pulse (index_pulse),
    .rqm         (rqm),
    .dio         (dio),
    .busy        (busy),
    .ser_load    (ser_load),
    .ser_gate    (ser_gate),
    .ser_deleted (ser_deleted)
);

// File: tb/test_wfi_intake.sv
// Bench: scoreboard of expected serializer bytes and result bytes.
module test_wfi_intake;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [1:0] cmd_unit = 2'd0;
    logic       cmd_head = 1'b0;
    logic [7:0] cmd_cyl = 8'd0;
    logic [7:0] cmd_rec = 8'd0;
    logic [2:0] cmd_size = 3'd0;
    logic [7:0] fmt_sectors = 8'd0;
    logic       wr_prot = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_din = 8'd0;
    logic       host_rd = 1'b0;
    logic [7:0] host_dout;
    logic       rqm, dio, busy;
    logic       ser_need = 1'b0;
    logic       index_pulse = 1'b0;
    logic       ser_load;
    logic [7:0] ser_byte;
    logic       ser_gate, ser_deleted;

    int   checks = 0;
    int   errors = 0;
    int   loads  = 0;
    bit   ended  = 1'b0;
    logic [7:0] exp_ser[$];

    always #5 clk = ~clk;

    wfi_intake i_wfi_intake (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: every hand-over must match the next expected byte (R6).
    always @(negedge clk) begin
        if (rst_n && ser_load) begin
            loads++;
            if (exp_ser.size() == 0) check(1'b0, "R6 unexpected load", ser_byte, 0);
            else begin
                automatic logic [7:0] e = exp_ser.pop_front();
                check(ser_byte == e, "R6 byte order", ser_byte, e);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic start_cmd(input logic [1:0] op, input logic [1:0] unit, input logic hd,
                             input logic [2:0] n, input logic [7:0] sect, input logic wp);
        cmd_op = op; cmd_unit = unit; cmd_head = hd; cmd_size = n;
        fmt_sectors = sect; wr_prot = wp; cmd_cyl = 8'h23; cmd_rec = 8'h05;
        cmd_start = 1'b1;
        tick();
        cmd_start = 1'b0;
    endtask

    // Driver: write one host byte and push it into the scoreboard.
    task automatic give(input logic [7:0] b);
        for (int w = 0; w < 50 && !(rqm && !dio); w++) tick();
        host_wr = 1'b1; host_din = b;
        exp_ser.push_back(b);
        tick();
        host_wr = 1'b0;
    endtask

    task automatic pull();
        ser_need = 1'b1;
        tick();
        ser_need = 1'b0;
    endtask

    task automatic read_result(input logic [7:0] s0, input logic [7:0] s1,
                               input logic [7:0] hb, input logic [7:0] n, input string req);
        logic [7:0] exp_res[$];
        exp_res = '{s0, s1, 8'h00, 8'h23, hb, 8'h05, n};
        for (int i = 0; i < 7; i++) begin
            automatic logic [7:0] e = exp_res.pop_front();
            check(rqm && dio, {req, " R12 result request"}, {rqm, dio}, 2'b11);
            check(host_dout == e, {req, " R12 result byte"}, host_dout, e);
            host_rd = 1'b1;
            tick();
            host_rd = 1'b0;
        end
        check(!busy && !rqm && !dio, "R12 idle after result", {busy, rqm, dio}, 0);
    endtask

    initial begin
        #1_000_000;
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) tick();
        check(!rqm && !dio && !ser_gate && !ser_deleted && !ser_load && !busy,
              "R1 reset state", {rqm, dio, ser_gate, ser_deleted, ser_load, busy}, 0);
        rst_n = 1'b1;
        tick();

        // R2: reserved code and idle host writes are ignored
        host_wr = 1'b1; tick(); host_wr = 1'b0;
        start_cmd(2'd3, 2'd0, 1'b0, 3'd0, 8'd1, 1'b0);
        tick();
        check(!busy && !rqm && !ser_gate, "R2 reserved code ignored", {busy, rqm, ser_gate}, 0);

        // R3: write-protected drive
        start_cmd(2'd0, 2'd1, 1'b0, 3'd0, 8'd1, 1'b1);
        check(!ser_gate && busy, "R3 no gate when protected", ser_gate, 0);
        read_result(8'h41, 8'h02, 8'h00, 8'h00, "R3");

        // R4 R8 R11: plain write, N=0 -> 128 bytes
        loads = 0;
        start_cmd(2'd0, 2'd2, 1'b1, 3'd0, 8'd1, 1'b0);
        check(ser_gate && rqm && !dio && !ser_deleted, "R4 R11 transfer setup",
              {ser_gate, rqm, dio, ser_deleted}, 4'b1100);
        // R2: a start while busy is ignored
        start_cmd(2'd2, 2'd0, 1'b0, 3'd0, 8'd1, 1'b0);
        check(busy && ser_gate && !dio, "R2 start while busy ignored", busy, 1);
        cmd_size = 3'd0;
        for (int i = 0; i < 128; i++) begin
            give(8'(i * 7 + 3));
            if (i == 0) check(!rqm, "R5 rqm drops after byte", rqm, 0);
            if (i == 0) begin
                // R5: a second write while rqm is low is ignored
                host_wr = 1'b1; host_din = 8'hEE; tick(); host_wr = 1'b0;
            end
            pull();
        end
        tick();
        check(loads == 128, "R8 write length", loads, 128);
        check(!ser_gate && rqm && dio, "R12 gate closes into result", {ser_gate, rqm, dio}, 3'b011);
        read_result(8'h06, 8'h00, 8'h01, 8'h00, "R8");

        // R11 R8: write deleted, N=1 -> 256 bytes
        loads = 0;
        start_cmd(2'd1, 2'd0, 1'b0, 3'd1, 8'd1, 1'b0);
        check(ser_deleted && ser_gate, "R11 deleted mark select", ser_deleted, 1);
        for (int i = 0; i < 256; i++) begin
            give(8'(255 - i));
            pull();
        end
        tick();
        check(loads == 256 && !ser_deleted, "R8 length N=1", loads, 256);
        read_result(8'h00, 8'h00, 8'h00, 8'h01, "R11");

        // R7: overrun after three bytes
        loads = 0;
        start_cmd(2'd0, 2'd3, 1'b0, 3'd0, 8'd1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            give(8'(8'h90 + i));
            pull();
        end
        tick();
        pull();
        check(!ser_gate && rqm && dio && loads == 3, "R7 overrun abort", loads, 3);
        read_result(8'h43, 8'h10, 8'h00, 8'h00, "R7");

        // R9: format of 2 sectors -> 8 ID bytes
        loads = 0;
        start_cmd(2'd2, 2'd1, 1'b1, 3'd2, 8'd2, 1'b0);
        check(ser_gate && !ser_deleted, "R11 format uses normal mark", ser_deleted, 0);
        for (int i = 0; i < 8; i++) begin
            give(8'(8'h40 + i));
            pull();
        end
        tick();
        check(loads == 8 && !ser_gate, "R9 format length", loads, 8);
        read_result(8'h05, 8'h00, 8'h01, 8'h02, "R9");

        // R10: index pulse during format, with a byte held
        loads = 0;
        start_cmd(2'd2, 2'd0, 1'b0, 3'd2, 8'd3, 1'b0);
        give(8'hA1); pull();
        give(8'hA2); pull();
        give(8'hA3);
        void'(exp_ser.pop_back());
        index_pulse = 1'b1; tick(); index_pulse = 1'b0;
        check(!ser_gate && rqm && dio && loads == 2, "R10 index abort", loads, 2);
        read_result(8'h40, 8'h10, 8'h00, 8'h02, "R10");

        check(exp_ser.size() == 0, "R6 scoreboard drained", exp_ser.size(), 0);
        finish_run();
    end
endmodule